// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, using only its 48-bit destination address. The address has already been pulled out of the frame. It arrives on `da` together with a one-cycle strobe. Byte k of the address sits in `da[8k+7:8k]`, where byte 0 is the first byte on the wire. A multicast address has bit 0 of byte 0 set, which is `da[0]`.

Two tables drive the decision:
- A set of exact-match slots. Every valid slot is compared against the incoming address at once.
- A 4096-bit multicast hash table. It is consulted only for a multicast address that misses every slot.

Software fills both tables through a plain 32-bit word interface. The exact slots are read back over the same interface, so a read-modify-write of a slot's upper word is safe. A two-bit setting chooses which 12 bits of address bytes 4 and 5 form the hash index. The decision leaves the block registered, as an accept flag plus a code naming what matched.

By convention, slot 0 carries the station's own address and the other slots start cleared. After reset every slot is invalid and every hash bit is zero.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `acc_valid` and `acc_accept` are 0, every exact slot reads back as zero (invalid), and every hash word reads back as zero.
- R2: With `cfg_sel`=0, word index 2n holds slot n's low word and word index 2n+1 holds its high word.
  - The low word carries bytes 0..3, with byte 0 in bits 7:0 and byte 3 in bits 31:24.
  - The high word carries byte 4 in bits 7:0, byte 5 in bits 15:8, and the slot-valid flag in bit 31.
  - Reading the high word returns exactly those fields, with bits 30:16 read as 0.
- R3: An address equal in all 48 bits to a valid slot is accepted with `acc_src`=01. This holds for multicast addresses too, which then skip the hash table. An address differing in any single bit from every valid slot gets no exact match.
- R4: A slot whose valid flag is clear never matches. Writing a high word with bit 31 clear disables that slot for every lookup strobed after that write's clock edge.
- R5: A multicast address that is not broadcast and misses all slots is accepted with `acc_src`=10 when its hash bit is 1. It is rejected with `acc_src`=00 when its hash bit is 0.
- R6: The 12-bit hash index `h` depends on `filt_type`, where b4 and b5 are address bytes 4 and 5:
  - type 0: (b4>>4)|(b5<<4)
  - type 1: (b4>>3)|(b5<<5)
  - type 2: (b4>>2)|(b5<<6)
  - type 3: b4|(b5<<8)

  Each result is truncated to 12 bits. `h[11:5]` selects a hash word and `h[4:0]` selects a bit within it.
- R7: A unicast address (`da[0]`=0) that misses every valid slot is rejected with `acc_src`=00, even when its hash bit is set.
- R8: The all-ones broadcast address is always accepted with `acc_src`=11, whatever the table contents.
- R9: `acc_valid` is high exactly one cycle after each `da_valid` strobe and at no other time. `acc_accept` and `acc_src` are meaningful in that cycle, and both are 0 whenever `acc_valid` is 0.
- R10: With `cfg_sel`=1, `cfg_addr` selects one of the 128 hash words, which can be written and read back. Writing 0 to all 128 words removes every hash acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the table word interface |
| cfg_sel | input | 1 | 0 selects the exact slots, 1 selects the hash table |
| cfg_addr | input | 7 | Word index inside the selected table |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the word at `cfg_sel`/`cfg_addr` (combinational) |
| filt_type | input | 2 | Chooses which bits of bytes 4 and 5 form the hash index |
| da_valid | input | 1 | Strobe: `da` holds an address to classify |
| da | input | 48 | Destination address, byte k in bits 8k+7:8k |
| acc_valid | output | 1 | Decision present, one cycle after the strobe |
| acc_accept | output | 1 | Frame accepted |
| acc_src | output | 2 | 00 none, 01 exact slot, 10 hash, 11 broadcast |

## Verification
The bench builds the filter with its default of 16 exact slots. This value brings the final slot, at word indices 30 and 31, within reach, and the bench uses it for a multicast exact entry that later gets disabled.

The hash table keeps its full 128 words. The bench sets bits for one multicast address under each of the four filter types. It also checks one hand-computed word and bit position, and ends by clearing every word.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_EXACT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [6:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [1:0]  filt_type,
  input  logic        da_valid,
  input  logic [47:0] da,
  output logic        acc_valid,
  output logic        acc_accept,
  output logic [1:0]  acc_src
);

  localparam int EW     = (NUM_EXACT > 1) ? $clog2(NUM_EXACT) : 1;
  localparam int HWORDS = 128;

  logic [47:0]          slot_addr [NUM_EXACT];
  logic [NUM_EXACT-1:0] slot_vld;
  logic [31:0]          htab [HWORDS];
  logic [NUM_EXACT-1:0] hit;
  logic [11:0]          hidx;
  logic [1:0]           src_n;

  wire          slot_ok  = !cfg_sel && ({1'b0, cfg_addr} < 8'(2 * NUM_EXACT));
  wire [EW-1:0] slot_idx = EW'(cfg_addr >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EXACT; i++) slot_addr[i] <= '0;
      slot_vld <= '0;
      for (int w = 0; w < HWORDS; w++) htab[w] <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) begin
        htab[cfg_addr] <= cfg_wdata;
      end else if (slot_ok) begin
        if (cfg_addr[0]) begin
          slot_addr[slot_idx][47:32] <= cfg_wdata[15:0];
          slot_vld[slot_idx]         <= cfg_wdata[31];
        end else begin
          slot_addr[slot_idx][31:0]  <= cfg_wdata;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel)
      cfg_rdata = htab[cfg_addr];
    else if (slot_ok) begin
      if (cfg_addr[0])
        cfg_rdata = {slot_vld[slot_idx], 15'b0, slot_addr[slot_idx][47:32]};
      else
        cfg_rdata = slot_addr[slot_idx][31:0];
    end
  end

  for (genvar g = 0; g < NUM_EXACT; g++) begin : g_cmp
    assign hit[g] = slot_vld[g] && (slot_addr[g] == da);
  end

  always_comb begin
    case (filt_type)
      2'd0:    hidx = {da[47:40], da[39:36]};
      2'd1:    hidx = {da[46:40], da[39:35]};
      2'd2:    hidx = {da[45:40], da[39:34]};
      default: hidx = {da[43:40], da[39:32]};
    endcase
  end

  wire [31:0] hword = htab[hidx[11:5]];
  wire        hbit  = hword[hidx[4:0]];
  wire        is_bc = &da;
  wire        ex_hit = |hit;

  assign src_n = is_bc            ? 2'b11 :
                 ex_hit           ? 2'b01 :
                 (da[0] && hbit)  ? 2'b10 : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid  <= 1'b0;
      acc_accept <= 1'b0;
      acc_src    <= 2'b00;
    end else begin
      acc_valid  <= da_valid;
      acc_accept <= da_valid && (src_n != 2'b00);
      acc_src    <= da_valid ? src_n : 2'b00;
    end
  end

  a_r9_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> acc_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !acc_valid && !acc_accept && acc_src == 2'b00);
  a_r8_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da == '1) |=> (acc_accept && acc_src == 2'b11));
  a_r3_exact_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && ex_hit && !is_bc) |=> (acc_accept && acc_src == 2'b01));
  a_r7_unicast_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0] && !ex_hit) |=> !acc_accept);
  a_r5_hash_src: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_src == 2'b10) |-> (acc_accept && $past(da[0])));

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [1:0]  filt_type;
  logic        da_valid;
  logic [47:0] da;
  logic        acc_valid, acc_accept;
  logic [1:0]  acc_src;

  always #4 clk = ~clk;

  rx_addr_filter #(.NUM_EXACT(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .filt_type(filt_type), .da_valid(da_valid), .da(da),
    .acc_valid(acc_valid), .acc_accept(acc_accept), .acc_src(acc_src));

  int checks = 0, fails = 0;
  logic [2:0]  exp_q [$];
  int          req_q [$];
  logic [47:0] m_addr [16];
  logic        m_vld  [16];
  logic [31:0] m_hash [128];

  localparam logic [47:0] A_ST = 48'h55_44_33_22_11_02;
  localparam logic [47:0] M1   = 48'h01_00_00_5E_00_01;
  localparam logic [47:0] M2   = 48'hCD_AB_7F_5E_00_01;
  localparam logic [47:0] M3   = 48'h12_34_7F_5E_00_01;
  localparam logic [47:0] U2   = 48'hCD_AB_7F_5E_00_00;
  localparam logic [47:0] A2   = 48'h66_55_44_33_22_10;

  function automatic logic [11:0] ref_hash(input logic [1:0] t, input logic [47:0] a);
    int r, l, b4, b5, h;
    r  = (t == 2'd3) ? 0 : 4 - int'(t);
    l  = 8 - r;
    b4 = int'(a[39:32]);
    b5 = int'(a[47:40]);
    h  = ((b4 >> r) | (b5 << l)) & 'hFFF;
    return h[11:0];
  endfunction

  function automatic logic [2:0] ref_out(input logic [47:0] a, input logic [1:0] t);
    logic [11:0] h;
    if (a == '1) return 3'b111;
    for (int i = 0; i < 16; i++)
      if (m_vld[i] && m_addr[i] == a) return 3'b101;
    if (a[0]) begin
      h = ref_hash(t, a);
      if (m_hash[h[11:5]][h[4:0]]) return 3'b110;
    end
    return 3'b000;
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && acc_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected acc_valid actual=1 expected=0");
      end else begin
        logic [2:0] e;
        int r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {29'b0, acc_accept, acc_src}, {29'b0, e}, "lookup result");
      end
    end
  end

  task automatic lookup(input logic [47:0] a, input int req);
    @(negedge clk);
    da = a; da_valid = 1'b1;
    exp_q.push_back(ref_out(a, filt_type));
    req_q.push_back(req);
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [6:0] adr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = adr; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic sel, input logic [6:0] adr, input logic [31:0] exp, input int req);
    @(negedge clk);
    cfg_sel = sel; cfg_addr = adr;
    #1;
    check(req, cfg_rdata, exp, "readback");
  endtask

  task automatic set_entry(input int n, input logic [47:0] a, input logic v);
    wr(1'b0, 7'(2 * n), a[31:0]);
    wr(1'b0, 7'(2 * n + 1), {v, 15'b0, a[47:32]});
    m_addr[n] = a; m_vld[n] = v;
  endtask

  task automatic set_hash(input int w, input logic [31:0] d);
    wr(1'b1, 7'(w), d);
    m_hash[w] = d;
  endtask

  task automatic set_hash_bit(input logic [1:0] t, input logic [47:0] a);
    logic [11:0] h;
    logic [31:0] d;
    h = ref_hash(t, a);
    d = m_hash[h[11:5]] | (32'h1 << h[4:0]);
    set_hash(int'(h[11:5]), d);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_addr[i] = '0; m_vld[i] = 1'b0; end
    for (int w = 0; w < 128; w++) m_hash[w] = '0;
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_wdata = 0;
    filt_type = 2'd0; da_valid = 0; da = '0;
    repeat (3) @(negedge clk);
    check(1, {30'b0, acc_valid, acc_accept}, 32'h0, "reset outputs");     // R1
    rd_check(1'b0, 7'd1, 32'h0, 1);                                       // R1 slot 0 high
    rd_check(1'b1, 7'h66, 32'h0, 1);                                      // R1 hash word
    rst_n = 1'b1;

    // R2: layout and read-back with junk bits dropped
    wr(1'b0, 7'd0, 32'h3322_1102);
    wr(1'b0, 7'd1, 32'hFFFF_5544);
    m_addr[0] = A_ST; m_vld[0] = 1'b1;
    rd_check(1'b0, 7'd0, 32'h3322_1102, 2);
    rd_check(1'b0, 7'd1, 32'h8000_5544, 2);

    // R3: exact matching
    lookup(A_ST, 3);
    lookup(A_ST ^ 48'h01_00_00_00_00_00, 3);
    lookup(A_ST ^ 48'h00_00_00_00_01_00, 3);
    set_entry(15, M1, 1'b1);
    rd_check(1'b0, 7'd31, 32'h8000_0100, 2);
    lookup(M1, 3);

    // R4: disabled slots
    wr(1'b0, 7'd31, 32'h0000_0100);
    m_vld[15] = 1'b0;
    lookup(M1, 4);
    set_entry(3, A2, 1'b0);
    lookup(A2, 4);

    // R5 / R6: hash under each type
    filt_type = 2'd0;
    lookup(M2, 5);
    set_hash_bit(2'd0, M2);
    rd_check(1'b1, 7'h66, 32'h0400_0000, 6);                              // R6 hand value 0xCDA
    lookup(M2, 5);
    lookup(M3, 6);
    for (int t = 1; t < 4; t++) begin
      filt_type = 2'(t);
      lookup(M2, 6);
      set_hash_bit(2'(t), M2);
      lookup(M2, 6);
      lookup(M3, 6);
    end

    // R7: unicast with hash bit set
    lookup(U2, 7);

    // R8: broadcast
    lookup('1, 8);

    // R10: hash write/read and full clear
    set_hash(5, 32'hA5A5_0F0F);
    rd_check(1'b1, 7'd5, 32'hA5A5_0F0F, 10);
    for (int w = 0; w < 128; w++) set_hash(w, 32'h0);
    rd_check(1'b1, 7'h66, 32'h0, 10);
    lookup(M2, 10);
    lookup('1, 8);

    // R9: single-cycle decision pulse
    lookup(A_ST, 9);
    @(negedge clk); #1;
    check(9, {31'b0, acc_valid}, 32'h0, "acc_valid after pulse");
    repeat (3) @(negedge clk);
    check(9, exp_q.size(), 32'h0, "pending decisions");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule